// File: doc/BRIEF.md
# Half-Pel SAD Motion Cost Unit

This unit computes the motion-estimation cost between a block of current pixels and a candidate reference block. The cost is the sum of absolute differences (SAD). The reference prediction can sit at a full-pel position or at one of three half-pel positions: horizontal, vertical or diagonal. For the half-pel positions the unit interpolates the prediction on the fly from the incoming reference rows, using rounded two-tap or four-tap averages. Pixels are 8-bit unsigned. A block is 8 pixels wide with a fixed height of 8, or 16 pixels wide with a height chosen per job.

A job begins with a one-cycle `start` pulse. The unit samples the mode, the width and the height on that pulse and clears its accumulator. Rows then arrive one per beat on a valid/ready stream, with each beat carrying one reference row and one current row. The vertical and diagonal modes need one more reference row than current rows. In these modes the first beat only primes a one-row store of the previous reference row. When the last current row has been taken, `done` pulses for one cycle, and `sad` holds the low 16 bits of the total.

Top module: `halfpel_sad`

## Requirements
- R1: In full-pel mode (`mode_i` = 0) the result is the sum, over all pixels of the block, of |ref[y][x] − cur[y][x]|. Pixel x of `ref_row` is bits [8x+7:8x], and pixel x of `cur_row` is bits [8x+7:8x].
- R2: In horizontal half-pel mode (`mode_i` = 1) each predicted pixel is (ref[y][x] + ref[y][x+1] + 1) >> 1. Every reference row therefore supplies width+1 pixels.
- R3: In vertical half-pel mode (`mode_i` = 2) each predicted pixel is (ref[y][x] + ref[y+1][x] + 1) >> 1. The first beat of the job carries reference row 0 only, and its current-row data has no effect. Each later beat k carries reference row k together with current row k−1.
- R4: In diagonal half-pel mode (`mode_i` = 3) each predicted pixel is (ref[y][x] + ref[y][x+1] + ref[y+1][x] + ref[y+1][x+1] + 2) >> 2. The beats are ordered as in R3.
- R5: With `wide_i` = 0 the block is 8 pixels wide and exactly 8 rows tall, whatever `height_i` holds. Current pixels 8..15 and reference pixels 9..16 have no effect.
- R6: With `wide_i` = 1 the block is 16 pixels wide and `height_i` rows tall. The differences from both 8-pixel halves add into one total.
- R7: `sad` is the total reduced modulo 2^16.
- R8: After reset, `done`, `row_ready` and `sad` are 0. `row_ready` is high from the cycle after an accepted start until the last beat is taken. `done` is high for exactly one cycle, in the cycle after the last beat, and `sad` is valid in that cycle.
- R9: While no job is running, `row_ready` is low and row beats have no effect. A `start` pulse during a running job has no effect.
- R10: Mode, width and height are taken only on the accepted start. Changes to these inputs during a job do not alter its result.
- R11: A height of 0 produces no beats, with `done` in the cycle after start and `sad` = 0. Any height, odd or even, completes in every mode.
- R12: Per-pixel differences do not wrap. A reference of 255 against a current of 0 adds 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job; sampled only when idle |
| mode_i | input | 2 | 0 full-pel, 1 horizontal, 2 vertical, 3 diagonal half-pel |
| wide_i | input | 1 | 1 for 16-wide blocks, 0 for 8-wide |
| height_i | input | 8 | Row count for 16-wide blocks |
| row_valid | input | 1 | A row beat is offered |
| row_ready | output | 1 | The unit accepts a row beat |
| ref_row | input | 136 | 17 reference pixels, pixel 0 in the low byte |
| cur_row | input | 128 | 16 current pixels, pixel 0 in the low byte |
| done | output | 1 | One-cycle completion pulse |
| sad | output | 16 | Accumulated cost, low 16 bits |

## Verification
The hardest cases to reach from the ports are those where the unit must ignore what it sees. The bench reaches them directly:
- It fills the priming beat of the vertical and diagonal modes with junk current-row data.
- In the middle of a job it raises `start` again and flips mode, width and height.
- It drives beats of extreme data while the unit is idle.
- In the narrow modes it places data in the unused upper pixels.

Wrapping past 16 bits needs at least seventeen 16-wide rows of maximal difference, so a dedicated job of flat 255-against-0 rows covers both the modular result and the non-wrapping per-pixel difference.

// File: rtl/halfpel_sad.sv
module halfpel_sad #(
  parameter int PW    = 8,
  parameter int MAX_W = 16,
  parameter int HW    = 8,
  parameter int OUT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [1:0]               mode_i,
  input  logic                     wide_i,
  input  logic [HW-1:0]            height_i,
  input  logic                     row_valid,
  output logic                     row_ready,
  input  logic [(MAX_W+1)*PW-1:0]  ref_row,
  input  logic [MAX_W*PW-1:0]      cur_row,
  output logic                     done,
  output logic [OUT_W-1:0]         sad
);
  localparam int HALF  = MAX_W / 2;
  localparam int SUM_W = PW + $clog2(MAX_W) + 1;

  logic                    busy, prime, wide_q;
  logic [1:0]              mode_q;
  logic [HW-1:0]           rows_left;
  logic [(MAX_W+1)*PW-1:0] prev_q;
  logic [OUT_W-1:0]        acc;
  logic [PW-1:0]           ad_v [MAX_W];
  logic [SUM_W-1:0]        row_sum;

  wire          launch = start & ~busy;
  wire [HW-1:0] nrows  = wide_i ? height_i : HW'(HALF);
  wire          beat   = busy & row_valid;

  assign row_ready = busy;
  assign sad       = acc;

  for (genvar x = 0; x < MAX_W; x++) begin : g_pix
    wire [PW-1:0] c  = cur_row[x*PW +: PW];
    wire [PW-1:0] r0 = ref_row[x*PW +: PW];
    wire [PW-1:0] r1 = ref_row[(x+1)*PW +: PW];
    wire [PW-1:0] p0 = prev_q[x*PW +: PW];
    wire [PW-1:0] p1 = prev_q[(x+1)*PW +: PW];
    wire [PW:0]   hs = {1'b0, r0} + {1'b0, r1} + (PW+1)'(1);
    wire [PW:0]   vs = {1'b0, p0} + {1'b0, r0} + (PW+1)'(1);
    wire [PW+1:0] ds = {2'b0, p0} + {2'b0, p1} + {2'b0, r0} + {2'b0, r1} + (PW+2)'(2);
    logic [PW-1:0]      pred;
    logic signed [PW:0] d;
    logic [PW-1:0]      mag;
    always_comb begin
      case (mode_q)
        2'd0:    pred = r0;
        2'd1:    pred = hs[PW:1];
        2'd2:    pred = vs[PW:1];
        default: pred = ds[PW+1:2];
      endcase
      d   = $signed({1'b0, c}) - $signed({1'b0, pred});
      mag = d[PW] ? PW'(-d) : PW'(d);
      ad_v[x] = (wide_q || x < HALF) ? mag : '0;
    end
  end

  always_comb begin
    row_sum = '0;
    for (int x = 0; x < MAX_W; x++) row_sum = row_sum + SUM_W'(ad_v[x]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      prime     <= 1'b0;
      wide_q    <= 1'b0;
      mode_q    <= 2'd0;
      rows_left <= '0;
      prev_q    <= '0;
      acc       <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy      <= (nrows != '0);
        done      <= (nrows == '0);
        mode_q    <= mode_i;
        wide_q    <= wide_i;
        rows_left <= nrows;
        prime     <= mode_i[1];
        acc       <= '0;
      end else if (beat) begin
        prev_q <= ref_row;
        if (prime) begin
          prime <= 1'b0;
        end else begin
          acc       <= acc + OUT_W'(row_sum);
          rows_left <= rows_left - 1'b1;
          if (rows_left == HW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !row_ready);
  assert_zero_rows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && nrows == '0) |=> (done && !row_ready && sad == '0));
  assert_clear_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (sad == '0));
  assert_prime_no_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && prime) |=> $stable(acc));
  assert_config_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (!busy || ($stable(mode_q) && $stable(wide_q))));
  assert_idle_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(acc));
endmodule

// File: tb/halfpel_sad_bench.sv
`timescale 1ns/1ps
module halfpel_sad_bench;
  logic         clk = 0, rst_n = 0, start = 0, wide_i = 0, row_valid = 0;
  logic [1:0]   mode_i = 0;
  logic [7:0]   height_i = 0;
  logic [135:0] ref_row = '0;
  logic [127:0] cur_row = '0;
  logic         row_ready, done;
  logic [15:0]  sad;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  halfpel_sad u_halfpel_sad (.clk(clk), .rst_n(rst_n), .start(start), .mode_i(mode_i),
    .wide_i(wide_i), .height_i(height_i), .row_valid(row_valid), .row_ready(row_ready),
    .ref_row(ref_row), .cur_row(cur_row), .done(done), .sad(sad));

  localparam int NV = 11;
  localparam int VM [NV] = '{0, 1, 2, 3, 0, 1, 2, 3, 2, 3, 1};
  localparam int VW [NV] = '{1, 1, 1, 1, 0, 0, 0, 0, 1, 1, 1};
  localparam int VH [NV] = '{16, 16, 16, 16, 3, 0, 5, 200, 5, 1, 3};
  localparam int VS [NV] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11};
  localparam string VR [NV] = '{"R1 R6", "R2 R6", "R3 R6", "R4 R6", "R5 R1", "R5 R2",
                                "R5 R3", "R5 R4", "R11 R3", "R11 R4", "R2"};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int refp(input bit flat, input int s, input int r, input int c);
    return flat ? 255 : ((s * 97 + r * 53 + c * 29 + r * c * 11 + (s * r * c) % 7) & 255);
  endfunction

  function automatic int curp(input bit flat, input int s, input int r, input int c);
    return flat ? 0 : ((s * 41 + r * 71 + c * 13 + r * c * 5 + 100) & 255);
  endfunction

  task automatic run_block(input int m, input int w, input int h, input int s,
                           input bit flat, input bit disturb, input string tag);
    int rows, width, beats, exp, pr;
    rows  = w ? h : 8;
    width = w ? 16 : 8;
    beats = (rows == 0) ? 0 : rows + (m >= 2 ? 1 : 0);
    exp = 0;
    for (int r = 0; r < rows; r++)
      for (int x = 0; x < width; x++) begin
        case (m)
          0: pr = refp(flat, s, r, x);
          1: pr = (refp(flat, s, r, x) + refp(flat, s, r, x + 1) + 1) >> 1;
          2: pr = (refp(flat, s, r, x) + refp(flat, s, r + 1, x) + 1) >> 1;
          default: pr = (refp(flat, s, r, x) + refp(flat, s, r, x + 1) +
                         refp(flat, s, r + 1, x) + refp(flat, s, r + 1, x + 1) + 2) >> 2;
        endcase
        exp += (curp(flat, s, r, x) > pr) ? curp(flat, s, r, x) - pr : pr - curp(flat, s, r, x);
      end
    exp &= 65535;
    @(negedge clk);
    start = 1; mode_i = 2'(m); wide_i = w[0]; height_i = 8'(h);
    @(negedge clk);
    start = 0;
    if (disturb) begin mode_i = 2'(m ^ 3); wide_i = ~w[0]; height_i = 8'(h + 3); end
    for (int b = 0; b < beats; b++) begin
      if (b == 2) begin
        row_valid = 0;
        if (disturb) start = 1;
        @(negedge clk);
        start = 0;
      end
      for (int x = 0; x < 17; x++)
        ref_row[x*8 +: 8] = (x > width) ? 8'hFF : 8'(refp(flat, s, b, x));
      for (int x = 0; x < 16; x++) begin
        if (x >= width) cur_row[x*8 +: 8] = 8'h00;
        else if (m >= 2) cur_row[x*8 +: 8] = (b == 0) ? 8'(x * 37 + 200) : 8'(curp(flat, s, b - 1, x));
        else cur_row[x*8 +: 8] = 8'(curp(flat, s, b, x));
      end
      row_valid = 1;
      check(row_ready === 1'b1, {tag, " R8 ready"}, int'(row_ready), 1);
      check(done === 1'b0, {tag, " R8 early done"}, int'(done), 0);
      @(negedge clk);
      row_valid = 0;
    end
    check(done === 1'b1, {tag, " R8 done"}, int'(done), 1);
    check(sad === 16'(exp), tag, int'(sad), exp);
    check(row_ready === 1'b0, {tag, " R8 ready low"}, int'(row_ready), 0);
    @(negedge clk);
    check(done === 1'b0, {tag, " R8 pulse"}, int'(done), 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(done === 1'b0, "R8 reset done", int'(done), 0);
    check(row_ready === 1'b0, "R8 reset ready", int'(row_ready), 0);
    check(sad === 16'd0, "R8 reset sad", int'(sad), 0);
    ref_row = '1; cur_row = '0; row_valid = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(row_ready === 1'b0 && done === 1'b0, "R9 idle beat", int'(row_ready), 0);
      check(sad === 16'd0, "R9 idle sad", int'(sad), 0);
    end
    row_valid = 0;
    for (int v = 0; v < NV; v++) run_block(VM[v], VW[v], VH[v], VS[v], 1'b0, 1'b0, VR[v]);
    run_block(0, 1, 20, 0, 1'b1, 1'b0, "R7 R12");
    run_block(3, 1, 6, 21, 1'b0, 1'b1, "R10 R9");
    run_block(2, 0, 0, 22, 1'b0, 1'b1, "R10 R3");
    run_block(1, 1, 0, 23, 1'b0, 1'b0, "R11");
    run_block(3, 1, 0, 24, 1'b0, 1'b0, "R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule